// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit timer/counter for a small microcontroller subsystem. It holds a running count, a second 16-bit register that serves as the reload value or the capture target, a control register and a mode register. All four are written and read through a simple register port: a 2-bit select, a write strobe, write data, and read data from a combinational multiplexer.

The count advances on one of four time bases. It can count internal clocks, either one per clock or one per `PRE_DIV` clocks, chosen by `fast_sel`. It can count falling edges on `event_in`. In baud mode it counts one step every two clocks. A second external input, `trig_in`, acts in one of three ways depending on the mode. It can copy the count into the capture register. It can force a reload of the count. In reload mode with down counting enabled, its level sets the count direction.

The block raises two flags. The overflow flag marks an overflow or underflow. The external flag marks a trigger edge, or in down-count mode it toggles on each wrap. Their OR, gated by an interrupt enable, drives `irq`. In baud mode, every overflow goes out as a one-clock pulse on `tx_tick`, on `rx_tick`, or on both, according to the two baud selects.

Top module: `cr_timer16`

## Requirements
- R1: After reset the count, reload, control and mode registers all read 0, and `irq`, `tx_tick` and `rx_tick` are 0.
- R2: `reg_sel` selects the register: 0 is the count, 1 is reload/capture, 2 is control, 3 is mode. A write with `reg_wr`=1 takes effect at the next clock edge. A read returns the register, zero-extended. Control bits: bit0 run, bit1 event mode, bit2 capture select, bit3 trigger enable, bit4 transmit baud select, bit5 receive baud select, bit6 external flag, bit7 overflow flag, bit8 interrupt enable. Mode bits: bit0 down-count enable, bit1 clear-on-capture.
- R3: With run=0 the count holds its value. With run=1, timer mode and `fast_sel`=1, it advances by one on every clock.
- R4: With run=1, timer mode and `fast_sel`=0, the count advances once every `PRE_DIV` enabled clocks.
- R5: In event mode, each falling edge of `event_in` advances the count by one while run=1. The edge is seen after a two-flop synchronizer.
- R6: Counting up, the step from FFFFh loads the reload value and sets the overflow flag. In capture mode, the step from FFFFh wraps to 0 instead.
- R7: In reload mode with down-count enabled and `trig_in` high, the count decrements. When the count equals the reload value, the next step loads FFFFh, sets the overflow flag and toggles the external flag. In this mode, `trig_in` edges cause no reload.
- R8: With trigger enable=1 and capture select=1, a falling edge on `trig_in` copies the count into the capture register and sets the external flag. If clear-on-capture is also set, the count becomes 0 at the same time.
- R9: With trigger enable=1 and capture select=0, a falling edge on `trig_in` loads the reload value into the count and sets the external flag.
- R10: With trigger enable=0, a falling edge on `trig_in` changes neither the count, the reload register nor the flags.
- R11: Either baud select forces baud mode. In baud mode the count steps once every two clocks while running, ignores the capture select, reloads on every overflow, and does not set the overflow flag. Each overflow drives a one-clock pulse on `tx_tick` if the transmit select is set, and on `rx_tick` if the receive select is set.
- R12: `irq` is 1 exactly when the interrupt enable is set and at least one flag is set. Both flags can be set and cleared by writing the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| trig_in | input | 1 | External trigger / direction input (asynchronous) |
| event_in | input | 1 | External event input for counting (asynchronous) |
| fast_sel | input | 1 | Timer rate: 1 = every clock, 0 = every PRE_DIV clocks |
| irq | output | 1 | Interrupt request |
| tx_tick | output | 1 | Transmit baud overflow pulse |
| rx_tick | output | 1 | Receive baud overflow pulse |

## Verification
The hardest case to reach is the down-count wrap. It needs down counting enabled, `trig_in` held high through the synchronizer before counting starts, and a count just above the reload value. Only then does the compare with the reload register trigger the FFFFh load and the external-flag toggle. The stimulus loads the count and the reload value while stopped, runs for a counted number of clocks, and reads the control flags while the timer is still running, because stopping it by a control write would also overwrite the flags. Baud pulses are counted at the ports over a window that the bench works out from the two-clock step pattern.

// File: rtl/cr_timer16_pkg.sv
package cr_timer16_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_MODE   = 2'd3
  } sel_e;

  typedef struct packed {
    logic irq_en;    // bit8
    logic ovf_flag;  // bit7
    logic ext_flag;  // bit6
    logic rx_baud;   // bit5
    logic tx_baud;   // bit4
    logic ext_en;    // bit3
    logic capt_sel;  // bit2
    logic evt_mode;  // bit1
    logic run;       // bit0
  } ctrl_t;

  typedef struct packed {
    logic capt_clr;  // bit1
    logic down_en;   // bit0
  } mode_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/cr_timer16_sync.sv
module cr_timer16_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh_q, sh_d;
    logic              last_q, last_d;

    always_comb begin
      sh_d   = {sh_q[STAGES-2:0], din[i]};
      last_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        last_q <= 1'b0;
      end else begin
        sh_q   <= sh_d;
        last_q <= last_d;
      end
    end

    assign level[i] = sh_q[STAGES-1];
    assign fall[i]  = last_q & ~sh_q[STAGES-1];

    // R5
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]);
  end

endmodule

// File: rtl/cr_timer16_tickgen.sv
module cr_timer16_tickgen #(
  parameter int PRE_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic baud,
  input  logic evt_mode,
  input  logic fast_sel,
  input  logic evt_fall,
  output logic tick
);

  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRE_DIV - 1);

  logic [PW-1:0] presc_q, presc_d;
  logic          half_q, half_d;
  logic          slow_mode, baud_run;

  assign slow_mode = run & ~baud & ~evt_mode & ~fast_sel;
  assign baud_run  = run & baud;

  always_comb begin
    tick    = 1'b0;
    presc_d = presc_q;
    half_d  = half_q;
    if (run) begin
      if (baud) begin
        half_d = ~half_q;
        tick   = half_q;
      end else if (evt_mode) begin
        tick = evt_fall;
      end else if (fast_sel) begin
        tick = 1'b1;
      end else begin
        tick    = (presc_q == PMAX);
        presc_d = tick ? '0 : presc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      half_q  <= 1'b0;
    end else begin
      presc_q <= presc_d;
      half_q  <= half_d;
    end
  end

  // R4
  presc_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PRE_DIV > 1 && tick && slow_mode) |-> !$past(tick && slow_mode));

  // R11
  baud_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && baud_run) |-> !$past(tick && baud_run));

endmodule

// File: rtl/cr_timer16_regs.sv
module cr_timer16_regs
  import cr_timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mode,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              ovf_evt,
  input  logic              trig_act,
  input  logic              ext_toggle,
  output ctrl_t             ctrl_q,
  output mode_t             mode_q
);

  ctrl_t ctrl_d;
  mode_t mode_d;
  logic  baud;

  assign baud = ctrl_q.tx_baud | ctrl_q.rx_baud;

  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    if (ovf_evt && !baud) ctrl_d.ovf_flag = 1'b1;
    if (trig_act)         ctrl_d.ext_flag = 1'b1;
    if (ext_toggle)       ctrl_d.ext_flag = ~ctrl_q.ext_flag;
    if (wr_ctrl)          ctrl_d = ctrl_t'(wdata);
    if (wr_mode)          mode_d = mode_t'(wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
    end
  end

  // R11
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && baud && !wr_ctrl) |=> ctrl_q.ovf_flag == $past(ctrl_q.ovf_flag));

  // R9
  trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_act && !wr_ctrl) |=> ctrl_q.ext_flag);

endmodule

// File: rtl/cr_timer16_core.sv
module cr_timer16_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             reload_mode,
  input  logic             capt_mode,
  input  logic             trig_act,
  input  logic             capt_clr,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_d, rld_d;
  logic             at_top, at_floor;

  assign at_top   = (cnt_q == TOP);
  assign at_floor = (cnt_q == rld_q);

  always_comb begin
    ovf_evt = tick & (down ? at_floor : at_top);
    cnt_d   = cnt_q;
    rld_d   = rld_q;
    if (tick) begin
      if (down) cnt_d = at_floor ? TOP : cnt_q - 1'b1;
      else      cnt_d = at_top ? (reload_mode ? rld_q : '0) : cnt_q + 1'b1;
    end
    if (trig_act) begin
      if (capt_mode) begin
        rld_d = cnt_q;
        if (capt_clr) cnt_d = '0;
      end else begin
        cnt_d = rld_q;
      end
    end
    if (wr_cnt) cnt_d = wdata;
    if (wr_rld) rld_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trig_act && !wr_cnt) |=> $stable(cnt_q));

  // R6
  up_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !down && reload_mode && !trig_act && !wr_cnt) |=> cnt_q == $past(rld_q));

  // R7
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && down && !trig_act && !wr_cnt) |=> cnt_q == TOP);

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_act && capt_mode && !wr_rld) |=> rld_q == $past(cnt_q));

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer16_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             trig_in,
  input  logic             event_in,
  input  logic             fast_sel,
  output logic             irq,
  output logic             tx_tick,
  output logic             rx_tick
);

  ctrl_t            ctrl_q;
  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [1:0]       s_level, s_fall;
  logic             baud, down, trig_act, ext_toggle, ovf_evt, tick;
  logic             wr_cnt, wr_rld, wr_ctrl, wr_mode;
  logic             reload_mode, capt_mode, dc_mode;

  assign wr_cnt  = reg_wr & (sel_e'(reg_sel) == SEL_COUNT);
  assign wr_rld  = reg_wr & (sel_e'(reg_sel) == SEL_RELOAD);
  assign wr_ctrl = reg_wr & (sel_e'(reg_sel) == SEL_CTRL);
  assign wr_mode = reg_wr & (sel_e'(reg_sel) == SEL_MODE);

  cr_timer16_sync #(.N(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({event_in, trig_in}),
    .level (s_level),
    .fall  (s_fall)
  );

  always_comb begin
    baud        = ctrl_q.tx_baud | ctrl_q.rx_baud;
    reload_mode = baud | ~ctrl_q.capt_sel;
    capt_mode   = ~baud & ctrl_q.capt_sel;
    dc_mode     = ~baud & ~ctrl_q.capt_sel & mode_q.down_en;
    down        = dc_mode & s_level[0];
    trig_act    = ctrl_q.ext_en & ~baud & s_fall[0] & ~dc_mode;
    ext_toggle  = ovf_evt & dc_mode;
  end

  cr_timer16_tickgen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .baud     (baud),
    .evt_mode (ctrl_q.evt_mode),
    .fast_sel (fast_sel),
    .evt_fall (s_fall[1]),
    .tick     (tick)
  );

  cr_timer16_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .down        (down),
    .reload_mode (reload_mode),
    .capt_mode   (capt_mode),
    .trig_act    (trig_act),
    .capt_clr    (mode_q.capt_clr),
    .wr_cnt      (wr_cnt),
    .wr_rld      (wr_rld),
    .wdata       (reg_wdata),
    .cnt_q       (cnt_q),
    .rld_q       (rld_q),
    .ovf_evt     (ovf_evt)
  );

  cr_timer16_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_mode    (wr_mode),
    .wdata      (reg_wdata[CTRL_W-1:0]),
    .ovf_evt    (ovf_evt),
    .trig_act   (trig_act),
    .ext_toggle (ext_toggle),
    .ctrl_q     (ctrl_q),
    .mode_q     (mode_q)
  );

  always_comb begin
    case (sel_e'(reg_sel))
      SEL_COUNT:  reg_rdata = cnt_q;
      SEL_RELOAD: reg_rdata = rld_q;
      SEL_CTRL:   reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      default:    reg_rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
    endcase
  end

  assign irq     = ctrl_q.irq_en & (ctrl_q.ovf_flag | ctrl_q.ext_flag);
  assign tx_tick = ovf_evt & ctrl_q.tx_baud;
  assign rx_tick = ovf_evt & ctrl_q.rx_baud;

  // R11
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick || rx_tick) |=> !(tx_tick || rx_tick));

  // R12
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q.ovf_flag || ctrl_q.ext_flag));

endmodule

// File: tb/cr_timer16_test.sv
module cr_timer16_test;

  localparam int PRE_DIV = 12;
  localparam int RUN   = 1,   EVT  = 2,  CAPT = 4,  EXTEN = 8;
  localparam int TXB   = 16,  RXB  = 32, EXTF = 64, OVF   = 128;
  localparam int IRQEN = 256;
  localparam int OBS_IRQ = 4, OBS_TX = 5, OBS_RX = 6;

  typedef struct {
    int    obs;
    int    exp;
    string req;
  } item_t;

  logic        clk, rst_n, reg_wr, trig_in, event_in, fast_sel;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq, tx_tick, rx_tick;

  item_t q[$];
  int    checks = 0, fails = 0, tx_n = 0, rx_n = 0;
  bit    done = 0;

  cr_timer16 #(.CNT_W(16), .PRE_DIV(PRE_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .event_in(event_in), .fast_sel(fast_sel), .irq(irq),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: counts baud pulses and pops expected items
  always @(negedge clk) begin
    int actual;
    item_t it;
    if (rst_n) begin
      if (tx_tick) tx_n++;
      if (rx_tick) rx_n++;
    end
    if (q.size() > 0) begin
      it = q.pop_front();
      case (it.obs)
        OBS_IRQ: actual = int'(irq);
        OBS_TX:  actual = tx_n;
        OBS_RX:  actual = rx_n;
        default: actual = int'(reg_rdata);
      endcase
      checks++;
      if (actual != it.exp) begin
        fails++;
        $display("FAIL %s obs=%0d actual=%h expected=%h", it.req, it.obs, actual, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input int sel, input int val);
    reg_sel = 2'(sel); reg_wdata = 16'(val); reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic expect_obs(input int obs, input int val, input string req);
    item_t it;
    if (obs < 4) reg_sel = 2'(obs);
    it.obs = obs; it.exp = val; it.req = req;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic trig_pulse();
    trig_in = 1'b1; idle(4);
    trig_in = 1'b0; idle(5);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    trig_in = 1'b0; event_in = 1'b0; fast_sel = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    expect_obs(0, 0, "R1");
    expect_obs(1, 0, "R1");
    expect_obs(2, 0, "R1");
    expect_obs(3, 0, "R1");
    expect_obs(OBS_IRQ, 0, "R1");

    // R2 register map
    wr(1, 16'hA5C3); expect_obs(1, 16'hA5C3, "R2");
    wr(3, 3);        expect_obs(3, 3, "R2");
    wr(3, 0);

    // R3 fast timer: 10 counts, then hold
    wr(0, 16'h0010); wr(2, RUN); idle(9); wr(2, 0);
    expect_obs(0, 16'h001A, "R3");
    idle(5);
    expect_obs(0, 16'h001A, "R3");

    // R4 prescaled: 25 enabled clocks -> 2 steps
    fast_sel = 1'b0;
    wr(0, 0); wr(2, RUN); idle(24); wr(2, 0);
    expect_obs(0, 2, "R4");
    fast_sel = 1'b1;

    // R5 event counting: 3 falling edges
    wr(0, 0); wr(2, RUN | EVT);
    for (int i = 0; i < 3; i++) begin
      event_in = 1'b1; idle(4);
      event_in = 1'b0; idle(4);
    end
    idle(4); wr(2, 0);
    expect_obs(0, 3, "R5");

    // R6 up overflow with reload
    wr(0, 16'hFFFD); wr(1, 16'h8000); wr(2, RUN); idle(3);
    expect_obs(2, RUN | OVF, "R6");
    wr(2, 0);
    expect_obs(0, 16'h8002, "R6");
    expect_obs(OBS_IRQ, 0, "R12");

    // R7 down counting, wrap at reload value
    wr(3, 1); trig_in = 1'b1; idle(4);
    wr(0, 16'h0102); wr(1, 16'h0100); wr(2, RUN); idle(3);
    expect_obs(2, RUN | OVF | EXTF, "R7");
    wr(2, 0);
    expect_obs(0, 16'hFFFD, "R7");
    wr(3, 0);

    // R9 reload on trigger edge (trig_in falls from 1)
    wr(2, EXTEN); wr(1, 16'h4321); wr(0, 16'h0007);
    trig_in = 1'b0; idle(5);
    expect_obs(0, 16'h4321, "R9");
    expect_obs(2, EXTEN | EXTF, "R9");

    // R10 trigger ignored when disabled
    wr(2, 0); wr(0, 16'h0055); wr(1, 16'h0AAA);
    trig_pulse();
    expect_obs(0, 16'h0055, "R10");
    expect_obs(1, 16'h0AAA, "R10");
    expect_obs(2, 0, "R10");

    // R8 capture, then capture with clear
    wr(2, CAPT | EXTEN); wr(0, 16'h1234); wr(1, 0);
    trig_pulse();
    expect_obs(1, 16'h1234, "R8");
    expect_obs(0, 16'h1234, "R8");
    expect_obs(2, CAPT | EXTEN | EXTF, "R8");
    wr(3, 2); wr(2, CAPT | EXTEN); wr(0, 16'h0BEE);
    trig_pulse();
    expect_obs(1, 16'h0BEE, "R8");
    expect_obs(0, 0, "R8");
    wr(3, 0);

    // R12 interrupt gating and software flags
    wr(2, EXTF);          expect_obs(OBS_IRQ, 0, "R12");
    wr(2, IRQEN | EXTF);  expect_obs(OBS_IRQ, 1, "R12");
    wr(2, IRQEN | OVF);   expect_obs(OBS_IRQ, 1, "R12");
    expect_obs(2, IRQEN | OVF, "R12");
    wr(2, IRQEN);         expect_obs(OBS_IRQ, 0, "R12");

    // R11 baud mode, transmit select
    wr(2, 0); wr(0, 16'hFFFE); wr(1, 16'hFFF0);
    wr(2, TXB | RUN); idle(4);
    expect_obs(OBS_TX, 1, "R11");
    expect_obs(OBS_RX, 0, "R11");
    expect_obs(2, TXB | RUN, "R11");
    wr(2, 0);
    expect_obs(0, 16'hFFF2, "R11");

    // R11 baud mode, receive select, capture select ignored
    wr(0, 16'hFFFF); wr(2, RXB | RUN | CAPT); idle(3);
    expect_obs(OBS_RX, 1, "R11");
    expect_obs(OBS_TX, 1, "R11");
    wr(2, 0);
    expect_obs(0, 16'hFFF2, "R11");
    expect_obs(1, 16'hFFF0, "R11");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule